// File: doc/BRIEF.md
# Serial Port Register Front End with Held-Off Interrupts

This block is the byte-wide register face of a classic serial port. A host reaches eight register offsets over a small peripheral bus with a 3-bit address, read and write strobes and 8-bit data. Incoming bytes arrive through a valid/ready stream into a one-byte holding register. Outgoing bytes leave as a one-cycle strobe with data. Bit-level framing, baud generation, FIFOs and modem pins are handled elsewhere.

Receive and transmit events do not raise the interrupt at once. Each event starts a holdoff timer of `HOLDOFF` clock cycles, and a second request while the timer runs starts it again. When the timer expires, the pending bit is set only if the matching enable is still on. The single interrupt line is high while either pending bit is set. An identification register reports the pending source with receive first. Turning the transmit enable on raises the transmit interrupt at once if the last transmit interrupt is older than the holdoff. Otherwise it waits out a fresh holdoff.

Top module: `uart_regfront`

## Requirements
- R1: Offsets 2 (write), 5, 6 and 7 (write) change no state; offsets 6 and 7 read 0x00; line control (offset 3) reads back the last value written; `bus_rdata` is 0x00 when `bus_rd` is low.
- R2: While line control bit 7 is 1, offsets 0 and 1 read 0x00, a write to offset 0 sends no byte, and a write to offset 1 leaves the enable register unchanged.
- R3: A read of offset 0 with bit 7 clear returns the held byte, or 0x00 if none, empties the holder and clears receive-pending.
- R4: A write to offset 0 with bit 7 clear drives `tx_strobe` high for exactly the next cycle with `tx_data` equal to the byte, clears transmit-pending, and starts a transmit holdoff if enable bit 1 is set.
- R5: Offset 2 reads 0x04 when receive is pending, otherwise 0x02 when transmit is pending, otherwise 0x01; a read returning 0x02 clears transmit-pending.
- R6: A request started at clock edge E sets its pending bit at edge E+HOLDOFF; a new request of the same kind while one waits restarts the count.
- R7: A pending bit is set on expiry only if its enable bit is set then; `irq` equals receive-pending OR transmit-pending.
- R8: Writing offset 1 with bit 1 set sets transmit-pending at that edge if more than HOLDOFF cycles have passed since the last transmit posting (or none has happened), otherwise starts a holdoff; writing it with bit 1 clear cancels the waiting request and clears transmit-pending.
- R9: Writing offset 1 with bit 0 set while a byte is held starts a receive holdoff; any other enable write cancels the waiting receive request and clears receive-pending.
- R10: Offset 5 reads 0x60 with bit 0 set when a byte is held.
- R11: Offset 4 reads 0x00 after reset; writing 0x1A makes it read 0x9A; all other writes are ignored.
- R12: `rx_ready` is high when the holder is empty or is being read in the same cycle; while full and not read, the held byte is stable; a byte accepted while enable bit 0 is set starts a receive holdoff.
- R13: After reset the enable, line control and modem control registers are zero, nothing is pending, `irq` is low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Holder can take a byte |
| tx_strobe | output | 1 | One-cycle send strobe |
| tx_data | output | 8 | Byte being sent |
| irq | output | 1 | Interrupt request line |

## Verification
A wrong count in a holdoff timer shows as `irq` rising one or more cycles early or late against the edge E+HOLDOFF. The bench pins it to one exact cycle, both for a single request and for a restarted one. A stale pending bit or a bad age counter shows on the next read of the identification register, or as `irq` being high when it should be low. This is checked right after each clearing access and again after a full holdoff with nothing pending. A held-byte or divisor-select fault shows in the very next data, line status or enable read.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [2:0] OFS_DATA       = 3'd0;
  localparam logic [2:0] OFS_IEN        = 3'd1;
  localparam logic [2:0] OFS_IDENT      = 3'd2;
  localparam logic [2:0] OFS_LINE_CTL   = 3'd3;
  localparam logic [2:0] OFS_MODEM_CTL  = 3'd4;
  localparam logic [2:0] OFS_LINE_STAT  = 3'd5;

  localparam int IEN_RX_BIT   = 0;
  localparam int IEN_TX_BIT   = 1;
  localparam int LCTL_DIV_BIT = 7;

  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_TX   = 8'h02;
  localparam logic [7:0] ID_RX   = 8'h04;

  localparam logic [7:0] LSTAT_IDLE    = 8'h60;
  localparam logic [7:0] MCTL_MAGIC_WR = 8'h1A;
  localparam logic [7:0] MCTL_MAGIC_RD = 8'h9A;
endpackage

// File: rtl/uart_holdoff_timer.sv
module uart_holdoff_timer #(
  parameter int HOLDOFF = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic fire
);
  localparam int CW = (HOLDOFF > 1) ? $clog2(HOLDOFF) : 1;

  logic          active_q, active_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    fire     = active_q && (cnt_q == '0);
    active_n = active_q;
    cnt_n    = cnt_q;
    if (start) begin
      active_n = 1'b1;
      cnt_n    = CW'(HOLDOFF - 1);
    end else if (cancel || fire) begin
      active_n = 1'b0;
    end else if (active_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
    end
  end

  generate
    if (HOLDOFF > 1) begin : g_delay_chk
      // R6
      restart_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !fire);
    end
  endgenerate

  // R6
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start) |=> !fire);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  output logic          in_ready,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_q, full_n, accept;
  logic [DW-1:0] data_q, data_n;

  always_comb begin
    in_ready = !full_q || pop;
    accept   = in_valid && in_ready;
    full_n   = accept ? 1'b1 : (pop ? 1'b0 : full_q);
    data_n   = accept ? in_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_n;
      data_q <= data_n;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int HOLDOFF = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ien_rx,
  input  logic ien_tx,
  input  logic rx_start,
  input  logic rx_cancel,
  input  logic rx_clr,
  input  logic tx_start,
  input  logic tx_cancel,
  input  logic tx_clr,
  input  logic tx_now,
  output logic rx_pend,
  output logic tx_pend,
  output logic tx_aged
);
  localparam int AW = $clog2(HOLDOFF + 1);

  logic          rx_fire, tx_fire, tx_post;
  logic          rx_pend_q, rx_pend_n, tx_pend_q, tx_pend_n;
  logic [AW-1:0] age_q, age_n;

  uart_holdoff_timer #(.HOLDOFF(HOLDOFF)) u_rx_tmr (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .cancel(rx_cancel), .fire(rx_fire));

  uart_holdoff_timer #(.HOLDOFF(HOLDOFF)) u_tx_tmr (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .cancel(tx_cancel), .fire(tx_fire));

  always_comb begin
    rx_pend_n = rx_pend_q;
    if (rx_fire && ien_rx) rx_pend_n = 1'b1;
    if (rx_clr)            rx_pend_n = 1'b0;

    tx_pend_n = tx_pend_q;
    if (tx_fire && ien_tx) tx_pend_n = 1'b1;
    if (tx_clr)            tx_pend_n = 1'b0;
    if (tx_now)            tx_pend_n = 1'b1;

    tx_post = (tx_fire && ien_tx) || tx_now;
    if (tx_post)                     age_n = '0;
    else if (age_q < AW'(HOLDOFF))   age_n = age_q + 1'b1;
    else                             age_n = age_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend_q <= 1'b0;
      tx_pend_q <= 1'b0;
      age_q     <= AW'(HOLDOFF);
    end else begin
      rx_pend_q <= rx_pend_n;
      tx_pend_q <= tx_pend_n;
      age_q     <= age_n;
    end
  end

  assign rx_pend = rx_pend_q;
  assign tx_pend = tx_pend_q;
  assign tx_aged = (age_q == AW'(HOLDOFF));

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> !rx_pend_q);
  // R8
  tx_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cancel && !tx_now) |=> !tx_pend_q);
  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_pend_q) |-> $past(ien_rx));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int HOLDOFF = 12,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_strobe,
  output logic [DW-1:0] tx_data,
  output logic          irq
);
  logic [DW-1:0] ien_q, ien_n, lcr_q, lcr_n, mcr_q, mcr_n, txd_q, txd_n;
  logic          txs_q, txs_n;
  logic          div_sel, data_rd, data_wr, ien_wr, ident_rd;
  logic          rx_full, rx_accept;
  logic [DW-1:0] rx_byte;
  logic          rx_start, rx_cancel, rx_clr, tx_start, tx_cancel, tx_clr, tx_now;
  logic          rx_pend, tx_pend, tx_aged;

  always_comb begin
    div_sel  = lcr_q[LCTL_DIV_BIT];
    data_rd  = bus_rd && (bus_addr == OFS_DATA) && !div_sel;
    data_wr  = bus_wr && (bus_addr == OFS_DATA) && !div_sel;
    ien_wr   = bus_wr && (bus_addr == OFS_IEN)  && !div_sel;
    ident_rd = bus_rd && (bus_addr == OFS_IDENT);
  end

  uart_rx_hold #(.DW(DW)) u_rx_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .pop(data_rd), .in_ready(rx_ready), .full(rx_full), .data(rx_byte));

  always_comb begin
    rx_accept = rx_valid && rx_ready;
    ien_n = ien_wr ? bus_wdata : ien_q;
    lcr_n = (bus_wr && bus_addr == OFS_LINE_CTL) ? bus_wdata : lcr_q;
    mcr_n = (bus_wr && bus_addr == OFS_MODEM_CTL && bus_wdata == MCTL_MAGIC_WR)
            ? MCTL_MAGIC_RD : mcr_q;
    txs_n = data_wr;
    txd_n = data_wr ? bus_wdata : txd_q;

    rx_start  = (rx_accept && ien_n[IEN_RX_BIT])
             || (ien_wr && bus_wdata[IEN_RX_BIT] && rx_full);
    rx_cancel = ien_wr && !(bus_wdata[IEN_RX_BIT] && rx_full);
    rx_clr    = data_rd || rx_cancel;
    tx_now    = ien_wr && bus_wdata[IEN_TX_BIT] && tx_aged;
    tx_start  = (data_wr && ien_q[IEN_TX_BIT])
             || (ien_wr && bus_wdata[IEN_TX_BIT] && !tx_aged);
    tx_cancel = ien_wr && !bus_wdata[IEN_TX_BIT];
    tx_clr    = data_wr || tx_cancel || (ident_rd && !rx_pend && tx_pend);
  end

  uart_irq_ctrl #(.HOLDOFF(HOLDOFF)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ien_rx(ien_n[IEN_RX_BIT]), .ien_tx(ien_n[IEN_TX_BIT]),
    .rx_start(rx_start), .rx_cancel(rx_cancel), .rx_clr(rx_clr),
    .tx_start(tx_start), .tx_cancel(tx_cancel), .tx_clr(tx_clr), .tx_now(tx_now),
    .rx_pend(rx_pend), .tx_pend(tx_pend), .tx_aged(tx_aged));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      txs_q <= 1'b0;
      txd_q <= '0;
    end else begin
      ien_q <= ien_n;
      lcr_q <= lcr_n;
      mcr_q <= mcr_n;
      txs_q <= txs_n;
      txd_q <= txd_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DATA:      bus_rdata = (div_sel || !rx_full) ? '0 : rx_byte;
        OFS_IEN:       bus_rdata = div_sel ? '0 : ien_q;
        OFS_IDENT:     bus_rdata = rx_pend ? ID_RX : (tx_pend ? ID_TX : ID_NONE);
        OFS_LINE_CTL:  bus_rdata = lcr_q;
        OFS_MODEM_CTL: bus_rdata = mcr_q;
        OFS_LINE_STAT: bus_rdata = LSTAT_IDLE | {{(DW-1){1'b0}}, rx_full};
        default:       bus_rdata = '0;
      endcase
    end
  end

  assign tx_strobe = txs_q;
  assign tx_data   = txd_q;
  assign irq       = rx_pend || tx_pend;

  // R4
  tx_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_strobe && tx_data == $past(bus_wdata)));
  // R2
  div_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_IEN && div_sel) |=> $stable(ien_q));
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb_top;
  localparam int H = 12;

  logic       clk, rst_n, bus_rd, bus_wr, rx_valid;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rx_data, tx_data;
  logic       rx_ready, tx_strobe, irq;
  int n_chk, n_fail;
  logic done;

  uart_regfront #(.HOLDOFF(H), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_data(tx_data), .irq(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_data = d; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R13 irq", {7'b0, irq}, 8'h00);
    chk("R13 rx_ready", {7'b0, rx_ready}, 8'h01);
    chk("R1 idle rdata", bus_rdata, 8'h00);
    bus_read(3'd1, v); chk("R13 enable", v, 8'h00);
    bus_read(3'd3, v); chk("R13 line ctl", v, 8'h00);
    bus_read(3'd4, v); chk("R11 modem ctl reset", v, 8'h00);
    bus_read(3'd2, v); chk("R5 none pending", v, 8'h01);
    bus_read(3'd5, v); chk("R10 line status empty", v, 8'h60);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    bus_write(3'd3, 8'h03); bus_read(3'd3, v); chk("R1 line ctl readback", v, 8'h03);
    bus_write(3'd4, 8'h05); bus_read(3'd4, v); chk("R11 other write ignored", v, 8'h00);
    bus_write(3'd4, 8'h1A); bus_read(3'd4, v); chk("R11 magic write", v, 8'h9A);
    bus_write(3'd7, 8'h55); bus_read(3'd7, v); chk("R1 scratch reads 0", v, 8'h00);
    bus_write(3'd6, 8'h33); bus_read(3'd6, v); chk("R1 modem status 0", v, 8'h00);
    bus_write(3'd2, 8'hC7); bus_write(3'd5, 8'hFF);
    bus_read(3'd2, v); chk("R1 fifo ctl write ignored", v, 8'h01);
    bus_read(3'd5, v); chk("R1 line status write ignored", v, 8'h60);
    bus_write(3'd3, 8'h00);
  endtask

  task automatic t_divisor;
    logic [7:0] v;
    bus_write(3'd3, 8'h83);
    bus_write(3'd1, 8'hFF);
    bus_write(3'd0, 8'h41);
    chk("R2 no send under divisor", {7'b0, tx_strobe}, 8'h00);
    bus_read(3'd1, v); chk("R2 divisor high reads 0", v, 8'h00);
    bus_read(3'd0, v); chk("R2 divisor low reads 0", v, 8'h00);
    bus_write(3'd3, 8'h03);
    bus_read(3'd1, v); chk("R2 enable untouched", v, 8'h00);
    chk("R2 irq untouched", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    rx_push(8'hA5);
    chk("R12 ready drops when full", {7'b0, rx_ready}, 8'h00);
    bus_read(3'd5, v); chk("R10 data ready", v, 8'h61);
    wait_cyc(H + 2);
    chk("R12 no request while disabled", {7'b0, irq}, 8'h00);
    bus_write(3'd1, 8'h01);
    wait_cyc(H - 1); chk("R9 not before holdoff", {7'b0, irq}, 8'h00);
    wait_cyc(1);     chk("R9 posted at holdoff", {7'b0, irq}, 8'h01);
    bus_read(3'd2, v); chk("R5 rx id", v, 8'h04);
    bus_read(3'd0, v); chk("R3 byte returned", v, 8'hA5);
    chk("R3 irq cleared", {7'b0, irq}, 8'h00);
    chk("R12 ready after read", {7'b0, rx_ready}, 8'h01);
    bus_read(3'd0, v); chk("R3 empty read", v, 8'h00);
    bus_read(3'd5, v); chk("R10 empty again", v, 8'h60);
    // restart: arrival starts a request, enable write restarts it
    rx_push(8'h3C);
    wait_cyc(5);
    bus_write(3'd1, 8'h01);
    wait_cyc(H - 1); chk("R6 restarted holdoff", {7'b0, irq}, 8'h00);
    wait_cyc(1);     chk("R6 post after restart", {7'b0, irq}, 8'h01);
    bus_read(3'd0, v); chk("R3 second byte", v, 8'h3C);
    // arrival with enable, then disable before expiry
    rx_push(8'h5A);
    wait_cyc(3);
    bus_write(3'd1, 8'h00);
    wait_cyc(H + 2); chk("R7 cancelled request", {7'b0, irq}, 8'h00);
    bus_read(3'd0, v); chk("R3 held byte kept", v, 8'h5A);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    bus_write(3'd1, 8'h02);
    chk("R8 immediate when aged", {7'b0, irq}, 8'h01);
    bus_read(3'd2, v); chk("R5 tx id", v, 8'h02);
    bus_read(3'd2, v); chk("R5 tx cleared by id read", v, 8'h01);
    bus_write(3'd1, 8'h02);
    chk("R8 no immediate when recent", {7'b0, irq}, 8'h00);
    wait_cyc(H - 1); chk("R8 delayed not early", {7'b0, irq}, 8'h00);
    wait_cyc(1);     chk("R8 delayed posted", {7'b0, irq}, 8'h01);
    bus_write(3'd0, 8'h3C);
    chk("R4 strobe", {7'b0, tx_strobe}, 8'h01);
    chk("R4 data", tx_data, 8'h3C);
    chk("R4 pending cleared", {7'b0, irq}, 8'h00);
    wait_cyc(1); chk("R4 strobe one cycle", {7'b0, tx_strobe}, 8'h00);
    wait_cyc(H - 2); chk("R4 holdoff not early", {7'b0, irq}, 8'h00);
    wait_cyc(1);     chk("R4 holdoff posted", {7'b0, irq}, 8'h01);
    bus_write(3'd1, 8'h00);
    chk("R8 disable clears", {7'b0, irq}, 8'h00);
    bus_write(3'd0, 8'h11);
    wait_cyc(H + 2); chk("R7 no post while disabled", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_prio;
    logic [7:0] v;
    wait_cyc(2 * H);
    bus_write(3'd1, 8'h03);
    chk("R8 immediate again", {7'b0, irq}, 8'h01);
    rx_push(8'h77);
    wait_cyc(H);
    bus_read(3'd2, v); chk("R5 rx outranks tx", v, 8'h04);
    bus_read(3'd2, v); chk("R5 tx kept behind rx", v, 8'h04);
    bus_read(3'd0, v); chk("R3 priority byte", v, 8'h77);
    bus_read(3'd2, v); chk("R5 tx after rx", v, 8'h02);
    bus_read(3'd2, v); chk("R5 none after both", v, 8'h01);
    chk("R7 irq low", {7'b0, irq}, 8'h00);
    bus_write(3'd1, 8'h00);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_divisor();
    t_rx();
    t_tx();
    t_prio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule